// File: doc/BRIEF.md
# DDR SDRAM Command and Power-State Tracker

This block sits beside a DDR SDRAM control bus and follows what the memory device is being told to do. On every rising clock edge it samples the chip select, the three command strobes, the clock enable, the bank-address bits and the address bus. It decodes the command and updates a per-bank record of which banks hold an open row. It also follows the device through its power states: active, power down with all banks idle, power down with a row open, and self refresh. It reports any command that breaks the bank or clock-enable rules.

The command strobe, the bank vector and the violation flag are registered. They change one clock after the edge that sampled the command. The power state is also registered, with one exception: leaving self refresh shows on the output as soon as the clock enable rises, without waiting for an edge.

The state machine `ddr_pwr_fsm` has four named states. `PWR_ACTIVE` moves to `PWR_SELF_REF`, `PWR_PDN_IDLE` or `PWR_PDN_OPEN` when the clock enable is sampled low. `PWR_PDN_IDLE` and `PWR_PDN_OPEN` return to `PWR_ACTIVE` on an edge with the clock enable high. `PWR_SELF_REF` returns to `PWR_ACTIVE` as soon as the clock enable is high, with no edge needed.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: While `rst_n` is low at a rising edge, the outputs after that edge are as follows: `bank_open` is all zero, `pwr_state` is 0 (active), `cmd_strobe` is zero and `violation` is 0.
- R2: The command is accepted only when three conditions hold together: the power state is active, `cke` is high and `cs_n` is low. Each accepted command sets exactly one bit of `cmd_strobe` for the clock that follows its edge. The codes are given as {ras_n,cas_n,we_n}:
  - bit 0: NOP = 111
  - bit 1: activate = 011
  - bit 2: read = 101
  - bit 3: write = 100
  - bit 4: precharge = 010
  - bit 5: auto refresh = 001
  - bit 8: burst stop = 110
  
  With `cs_n` high, the strobe is zero and the banks do not change.
- R3: Code 000 is a mode register load. With `ba` equal to 0 it sets strobe bit 6 (base register). With any other `ba` value it sets strobe bit 7 (extended register).
- R4: An activate marks bank `ba` open. A precharge with `addr[10]` low closes only bank `ba`. A precharge with `addr[10]` high closes every bank.
- R5: A read or write with `addr[10]` high closes bank `ba` once accepted. With `addr[10]` low, the bank stays open.
- R6: `violation` rises for any of these: an activate to a bank that is already open, a read or write to an idle bank, or an auto refresh or mode register load while any bank is open.
- R7: In the active state, a sampled-low `cke` moves the power state on that edge and sets no strobe bit. The target state depends on the banks and the command:
  - all banks idle: 1 (idle power down);
  - all banks idle and an auto refresh code: 3 (self refresh);
  - any bank open: 2 (open-row power down).
  
  Power state 1 or 3 always comes with all banks idle.
- R8: In a power-down state, commands are ignored and the banks keep their state. The state returns to 0 on the first edge with `cke` high, and the command at that edge is ignored.
- R9: In self refresh, `pwr_state` reads 0 as soon as `cke` is high, before any clock edge. A command at the next edge is accepted.
- R10: `violation` also rises in two more cases. The first is a read or write code with `cs_n` low and `cke` low in the active state. The second is a self-refresh entry while a bank is open, which enters state 2 instead.
- R11: `violation` is high only in the clock after an offending edge. It returns low after an edge with no offence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; inputs sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, command bit |
| cas_n | input | 1 | Column strobe, command bit |
| we_n | input | 1 | Write enable, command bit |
| ba | input | 2 | Bank address |
| addr | input | 13 | Row or column address; bit 10 selects auto-precharge or all-bank precharge |
| cmd_strobe | output | 9 | One-hot accepted command, one clock after its edge |
| bank_open | output | 4 | One bit per bank, high while a row is open |
| pwr_state | output | 2 | 0 active, 1 idle power down, 2 open-row power down, 3 self refresh |
| violation | output | 1 | Protocol violation pulse |

## Verification
The bench builds the tracker with its default parameters: four banks, a 13-bit address and the auto-precharge flag on bit 10. With four banks, the tests can open a non-adjacent pair such as banks 1 and 3. This lets a single-bank precharge be told apart from an all-bank precharge. Since every bank address is reachable, a target bank can be compared against each of the others. The 13-bit bus places bit 10 mid-word, so a stray use of a neighbouring address bit gives a different bank vector.

// File: rtl/ddr_trk_pkg.sv
package ddr_trk_pkg;

    localparam int CMD_COUNT = 9;

    typedef enum logic [3:0] {
        CMD_NOP  = 4'd0,
        CMD_ACT  = 4'd1,
        CMD_RD   = 4'd2,
        CMD_WR   = 4'd3,
        CMD_PRE  = 4'd4,
        CMD_REF  = 4'd5,
        CMD_MRS  = 4'd6,
        CMD_EMRS = 4'd7,
        CMD_BST  = 4'd8
    } cmd_e;

    typedef enum logic [1:0] {
        PWR_ACTIVE   = 2'd0,
        PWR_PDN_IDLE = 2'd1,
        PWR_PDN_OPEN = 2'd2,
        PWR_SELF_REF = 2'd3
    } pwr_e;

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
    import ddr_trk_pkg::*;
#(
    parameter int BA_W = 2
) (
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic [BA_W-1:0] ba,
    output cmd_e            cmd
);

    always_comb begin
        unique case ({ras_n, cas_n, we_n})
            3'b111:  cmd = CMD_NOP;
            3'b011:  cmd = CMD_ACT;
            3'b101:  cmd = CMD_RD;
            3'b100:  cmd = CMD_WR;
            3'b010:  cmd = CMD_PRE;
            3'b001:  cmd = CMD_REF;
            3'b000:  cmd = (ba == '0) ? CMD_MRS : CMD_EMRS;
            3'b110:  cmd = CMD_BST;
            default: cmd = CMD_NOP;
        endcase
    end

endmodule

// File: rtl/ddr_bank_state.sv
module ddr_bank_state
    import ddr_trk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BA_W      = 2,
    parameter int ADDR_W    = 13,
    parameter int AP_BIT    = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_en,
    input  cmd_e                 cmd,
    input  logic [BA_W-1:0]      ba,
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_BANKS-1:0] bank_open,
    output logic                 tgt_open,
    output logic                 all_idle
);

    logic ap_flag;
    assign ap_flag  = addr[AP_BIT];
    assign tgt_open = bank_open[ba];
    assign all_idle = (bank_open == '0);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = (ba == BA_W'(b));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_open[b] <= 1'b0;
            end else if (cmd_en) begin
                case (cmd)
                    CMD_ACT: if (hit) bank_open[b] <= 1'b1;
                    CMD_PRE: if (hit || ap_flag) bank_open[b] <= 1'b0;
                    CMD_RD,
                    CMD_WR:  if (hit && ap_flag) bank_open[b] <= 1'b0;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/ddr_pwr_fsm.sv
module ddr_pwr_fsm
    import ddr_trk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cke,
    input  logic sr_req,
    input  logic all_idle,
    output pwr_e eff_state
);

    pwr_e state_q;
    pwr_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PWR_ACTIVE;
        else        state_q <= state_d;
    end

    // outputs: self-refresh exit is visible as soon as cke is high
    always_comb begin
        eff_state = state_q;
        if (state_q == PWR_SELF_REF && cke) eff_state = PWR_ACTIVE;
    end

    // next-state logic
    always_comb begin
        state_d = eff_state;
        unique case (eff_state)
            PWR_ACTIVE: begin
                if (!cke) begin
                    if (!all_idle)   state_d = PWR_PDN_OPEN;
                    else if (sr_req) state_d = PWR_SELF_REF;
                    else             state_d = PWR_PDN_IDLE;
                end
            end
            PWR_PDN_IDLE,
            PWR_PDN_OPEN: if (cke) state_d = PWR_ACTIVE;
            PWR_SELF_REF: state_d = PWR_SELF_REF;
            default:      state_d = PWR_ACTIVE;
        endcase
    end

endmodule

// File: rtl/ddr_cmd_tracker.sv
module ddr_cmd_tracker
    import ddr_trk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 13,
    parameter int AP_BIT    = 10,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cke,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic [BA_W-1:0]      ba,
    input  logic [ADDR_W-1:0]    addr,
    output logic [CMD_COUNT-1:0] cmd_strobe,
    output logic [NUM_BANKS-1:0] bank_open,
    output logic [1:0]           pwr_state,
    output logic                 violation
);

    cmd_e                 cmd;
    pwr_e                 pstate;
    logic                 in_active;
    logic                 cmd_ok;
    logic                 sr_req;
    logic                 tgt_open;
    logic                 all_idle;
    logic                 is_rw;
    logic                 viol_d;
    logic [CMD_COUNT-1:0] strobe_d;

    ddr_cmd_decode #(.BA_W(BA_W)) u_dec (
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .ba    (ba),
        .cmd   (cmd)
    );

    ddr_bank_state #(
        .NUM_BANKS (NUM_BANKS),
        .BA_W      (BA_W),
        .ADDR_W    (ADDR_W),
        .AP_BIT    (AP_BIT)
    ) u_banks (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_en    (cmd_ok),
        .cmd       (cmd),
        .ba        (ba),
        .addr      (addr),
        .bank_open (bank_open),
        .tgt_open  (tgt_open),
        .all_idle  (all_idle)
    );

    ddr_pwr_fsm u_pwr (
        .clk       (clk),
        .rst_n     (rst_n),
        .cke       (cke),
        .sr_req    (sr_req),
        .all_idle  (all_idle),
        .eff_state (pstate)
    );

    assign in_active = (pstate == PWR_ACTIVE);
    assign cmd_ok    = in_active && cke && !cs_n;
    assign sr_req    = !cs_n && (cmd == CMD_REF);
    assign is_rw     = (cmd == CMD_RD) || (cmd == CMD_WR);
    assign pwr_state = pstate;

    for (genvar i = 0; i < CMD_COUNT; i++) begin : g_strobe
        assign strobe_d[i] = cmd_ok && (cmd == cmd_e'(i));
    end

    always_comb begin
        viol_d = 1'b0;
        if (cmd_ok) begin
            if (cmd == CMD_ACT && tgt_open)  viol_d = 1'b1;
            if (is_rw && !tgt_open)          viol_d = 1'b1;
            if ((cmd == CMD_REF || cmd == CMD_MRS || cmd == CMD_EMRS) && !all_idle)
                viol_d = 1'b1;
        end
        if (in_active && !cke && !cs_n) begin
            if (is_rw)                       viol_d = 1'b1;
            if (cmd == CMD_REF && !all_idle) viol_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_strobe <= '0;
            violation  <= 1'b0;
        end else begin
            cmd_strobe <= strobe_d;
            violation  <= viol_d;
        end
    end

endmodule

// File: rtl/ddr_tracker_chk.sv
module ddr_tracker_chk #(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 13,
    parameter int AP_BIT    = 10,
    parameter int BA_W      = 2,
    parameter int CMD_W     = 9
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cke,
    input logic                 cs_n,
    input logic                 ras_n,
    input logic                 cas_n,
    input logic                 we_n,
    input logic [ADDR_W-1:0]    addr,
    input logic [CMD_W-1:0]     cmd_strobe,
    input logic [NUM_BANKS-1:0] bank_open,
    input logic [1:0]           pwr_state
);

    assert_strobe_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_strobe));

    assert_all_precharge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd0 && cke && !cs_n && !ras_n && cas_n && !we_n && addr[AP_BIT])
        |=> (bank_open == '0));

    assert_lowcke_no_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd0 && !cke) |=> (cmd_strobe == '0));

    assert_idle_states_banks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd1 || pwr_state == 2'd3) |-> (bank_open == '0));

    assert_pdn_banks_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state != 2'd0 && !cke) |=> $stable(bank_open));

endmodule

bind ddr_cmd_tracker ddr_tracker_chk #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W),
    .AP_BIT    (AP_BIT),
    .BA_W      (BA_W),
    .CMD_W     (ddr_trk_pkg::CMD_COUNT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cke        (cke),
    .cs_n       (cs_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .addr       (addr),
    .cmd_strobe (cmd_strobe),
    .bank_open  (bank_open),
    .pwr_state  (pwr_state)
);

// File: tb/tb_ddr_cmd_tracker.sv
module tb_ddr_cmd_tracker;

    localparam logic [2:0] C_NOP = 3'b111, C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100,
                           C_PRE = 3'b010, C_REF = 3'b001, C_MRS = 3'b000, C_BST = 3'b110;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1;
    logic        cs_n = 1'b1;
    logic        ras_n = 1'b1;
    logic        cas_n = 1'b1;
    logic        we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [12:0] addr = '0;
    logic [8:0]  cmd_strobe;
    logic [3:0]  bank_open;
    logic [1:0]  pwr_state;
    logic        violation;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ddr_cmd_tracker dut (
        .clk (clk), .rst_n (rst_n), .cke (cke), .cs_n (cs_n),
        .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n), .ba (ba), .addr (addr),
        .cmd_strobe (cmd_strobe), .bank_open (bank_open),
        .pwr_state (pwr_state), .violation (violation)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // drive one command cycle, then wait until after the edge for outputs
    task automatic cyc(input logic c_cs, input logic [2:0] code, input logic k,
                       input logic [1:0] b, input logic [12:0] a);
        cs_n = c_cs; {ras_n, cas_n, we_n} = code; cke = k; ba = b; addr = a;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cmd(input logic [2:0] code, input logic [1:0] b, input logic ap);
        cyc(1'b0, code, 1'b1, b, ap ? 13'h0400 : 13'h0000);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        cyc(1'b1, C_NOP, 1'b1, 2'd0, 13'd0);
        cyc(1'b1, C_NOP, 1'b1, 2'd0, 13'd0);
        chk("R1", "banks", bank_open, 0);
        chk("R1", "pwr", pwr_state, 0);
        chk("R1", "strobe", cmd_strobe, 0);
        chk("R1", "violation", violation, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_decode;
        cmd(C_NOP, 2'd0, 1'b0); chk("R2", "nop strobe", cmd_strobe, 9'h001);
        cmd(C_BST, 2'd0, 1'b0); chk("R2", "bst strobe", cmd_strobe, 9'h100);
        cmd(C_ACT, 2'd0, 1'b0); chk("R2", "act strobe", cmd_strobe, 9'h002);
        cmd(C_RD,  2'd0, 1'b0); chk("R2", "rd strobe", cmd_strobe, 9'h004);
        cmd(C_WR,  2'd0, 1'b0); chk("R2", "wr strobe", cmd_strobe, 9'h008);
        cmd(C_PRE, 2'd0, 1'b0); chk("R2", "pre strobe", cmd_strobe, 9'h010);
        cmd(C_REF, 2'd0, 1'b0); chk("R2", "ref strobe", cmd_strobe, 9'h020);
        chk("R2", "ref no violation", violation, 0);
        cmd(C_MRS, 2'd0, 1'b0); chk("R3", "base mode strobe", cmd_strobe, 9'h040);
        cmd(C_MRS, 2'd1, 1'b0); chk("R3", "ext mode strobe", cmd_strobe, 9'h080);
        cyc(1'b1, C_ACT, 1'b1, 2'd2, 13'd0);
        chk("R2", "deselect strobe", cmd_strobe, 0);
        chk("R2", "deselect banks", bank_open, 0);
    endtask

    task automatic t_banks;
        cmd(C_ACT, 2'd1, 1'b0); cmd(C_ACT, 2'd3, 1'b0);
        chk("R4", "open 1 and 3", bank_open, 4'b1010);
        cmd(C_PRE, 2'd1, 1'b0); chk("R4", "single precharge", bank_open, 4'b1000);
        cmd(C_ACT, 2'd0, 1'b0); cmd(C_ACT, 2'd2, 1'b0);
        chk("R4", "three open", bank_open, 4'b1101);
        cmd(C_PRE, 2'd0, 1'b1); chk("R4", "all precharge", bank_open, 4'b0000);
        cmd(C_ACT, 2'd2, 1'b0); cmd(C_RD, 2'd2, 1'b1);
        chk("R5", "read autoprecharge", bank_open, 4'b0000);
        cmd(C_ACT, 2'd1, 1'b0); cmd(C_WR, 2'd1, 1'b0);
        chk("R5", "write keeps open", bank_open, 4'b0010);
        cmd(C_WR, 2'd1, 1'b1); chk("R5", "write autoprecharge", bank_open, 4'b0000);
        chk("R5", "no violation", violation, 0);
    endtask

    task automatic t_viol;
        cmd(C_ACT, 2'd0, 1'b0); chk("R6", "first act clean", violation, 0);
        cmd(C_ACT, 2'd0, 1'b0); chk("R6", "act to open bank", violation, 1);
        cmd(C_NOP, 2'd0, 1'b0); chk("R11", "pulse clears", violation, 0);
        cmd(C_RD, 2'd3, 1'b0);  chk("R6", "read idle bank", violation, 1);
        cmd(C_REF, 2'd0, 1'b0); chk("R6", "refresh with open", violation, 1);
        cmd(C_MRS, 2'd0, 1'b0); chk("R6", "mode load with open", violation, 1);
        cmd(C_PRE, 2'd0, 1'b1); chk("R11", "clean after", violation, 0);
    endtask

    task automatic t_power;
        cyc(1'b0, C_NOP, 1'b0, 2'd0, 13'd0);
        chk("R7", "idle power down", pwr_state, 1);
        chk("R7", "no strobe on entry", cmd_strobe, 0);
        cyc(1'b0, C_ACT, 1'b0, 2'd0, 13'd0);
        chk("R8", "ignored in power down", bank_open, 0);
        cyc(1'b0, C_ACT, 1'b1, 2'd0, 13'd0);
        chk("R8", "exit to active", pwr_state, 0);
        chk("R8", "exit edge command ignored", bank_open, 0);
        cmd(C_ACT, 2'd0, 1'b0);
        cyc(1'b0, C_NOP, 1'b0, 2'd0, 13'd0);
        chk("R7", "open-row power down", pwr_state, 2);
        cyc(1'b0, C_PRE, 1'b0, 2'd0, 13'h0400);
        chk("R8", "banks held", bank_open, 4'b0001);
        cyc(1'b0, C_NOP, 1'b1, 2'd0, 13'd0);
        chk("R8", "exit open-row", pwr_state, 0);
        cmd(C_PRE, 2'd0, 1'b1);
        cyc(1'b0, C_REF, 1'b0, 2'd0, 13'd0);
        chk("R7", "self refresh entry", pwr_state, 3);
        chk("R7", "no strobe sr", cmd_strobe, 0);
        cyc(1'b1, C_NOP, 1'b0, 2'd0, 13'd0);
        chk("R7", "stays self refresh", pwr_state, 3);
        cke = 1'b1;
        #1;
        chk("R9", "async exit", pwr_state, 0);
        cmd(C_ACT, 2'd1, 1'b0);
        chk("R9", "command after exit", bank_open, 4'b0010);
        chk("R9", "strobe after exit", cmd_strobe, 9'h002);
    endtask

    task automatic t_cke_viol;
        cyc(1'b0, C_RD, 1'b0, 2'd1, 13'd0);
        chk("R10", "read with cke low", violation, 1);
        chk("R10", "enters open-row pd", pwr_state, 2);
        cyc(1'b1, C_NOP, 1'b1, 2'd0, 13'd0);
        chk("R11", "violation clears", violation, 0);
        cyc(1'b0, C_REF, 1'b0, 2'd0, 13'd0);
        chk("R10", "sr with open bank", violation, 1);
        chk("R10", "sr open goes pd", pwr_state, 2);
        cyc(1'b1, C_NOP, 1'b1, 2'd0, 13'd0);
        cmd(C_PRE, 2'd0, 1'b1);
        chk("R4", "final idle", bank_open, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset;
        t_decode;
        t_banks;
        t_viol;
        t_power;
        t_cke_viol;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule